// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block sits next to a small processor core and turns a set of peripheral request lines into one interrupt request with a jump address. Every request line, including one non-maskable line, is sampled on each clock edge into a pending latch. A line that is high for only one cycle therefore stays pending until the core services it. Maskable sources must have their mask bit set and the global enable on before they are eligible. The non-maskable source is always eligible. Among the eligible sources, one is chosen by fixed priority. Its service-routine address is looked up in a programmable vector table and presented to the core.

The core accepts the interrupt by pulsing an acknowledge and, in the same cycle, giving the program counter of the instruction it was about to fetch. The block stores that address in a return register and clears the pending bit of the source it had presented. Software reaches the block through a word-addressed register port. Through that port it can set pending bits to fake a request, clear pending bits, load the mask and the enable, and program vector entries. Any vector entry that has not been written returns a shared default handler address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A request line that is high in any cycle sets its pending bit at the next clock edge, and the bit stays set after the line drops. Pending bits read back at register address 0x00, with maskable source i at bit i and the non-maskable source at bit NSRC.
- R2: A maskable source whose mask bit is 0 never raises `irq_o`, but its pending bit is kept. The mask is read and written at address 0x02, with bit i belonging to source i.
- R3: The non-maskable source ignores the mask and the global enable. Whenever its pending bit is set, `irq_o` is high and `src_o` equals NSRC.
- R4: Priority is fixed. The non-maskable source wins first. After it, the eligible maskable source with the lowest index wins.
- R5: At the same clock edge that captures an eligible request, `irq_o` rises, `src_o` shows the winning source and `vec_o` shows that source's vector entry. After reset, `irq_o` is 0.
- R6: When `core_ack` is high while `irq_o` is high, the pending bit of the source shown on `src_o` clears at that edge. At the same edge, `core_pc` is copied into `ret_pc_o`.
- R7: If a request for the acknowledged source arrives in the same cycle as the acknowledge, its pending bit stays set, and the source is presented again.
- R8: Writing address 0x00 sets every pending bit whose data bit is 1, and the result behaves exactly like a hardware request. Writing address 0x01 clears every pending bit whose data bit is 1.
- R9: The vector entry for source i is at address 0x10+i, and the non-maskable entry is at 0x10+NSRC. Each entry reads as DEF_VEC and is presented as DEF_VEC until it is written.
- R10: Bit 0 of address 0x03 is the global enable. While it is 0, no maskable source raises `irq_o`, and its pending bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NSRC | Maskable peripheral request lines |
| nmi_line | input | 1 | Non-maskable request line |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the `cfg_addr` of the previous cycle |
| irq_o | output | 1 | Interrupt request to the core |
| src_o | output | IW | Index of the presented source |
| vec_o | output | AW | Service-routine address of the presented source |
| core_ack | input | 1 | Core accepts the presented interrupt |
| core_pc | input | AW | Address of the interrupted instruction |
| ret_pc_o | output | AW | Saved return address |

## Verification
Two things can land on the same pending bit in one cycle: the core's acknowledge, which clears the bit, and a new request on the same line, which sets it. The bench first brings source 0 up as the presented source. It then raises the acknowledge and line 0 together in a single cycle. It judges the result by checking that `irq_o` stays high with `src_o` still 0 after that edge, while `ret_pc_o` still captures the program counter. A second, plain acknowledge must then leave nothing pending. Every other service is checked by a scoreboard that compares the expected order of sources and their vectors against what the core side sees.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [5:0] {
    REG_PSET = 6'h00,
    REG_PCLR = 6'h01,
    REG_MASK = 6'h02,
    REG_CTRL = 6'h03,
    REG_VEC0 = 6'h10
  } cfg_reg_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NB = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] hw_req,
  input  logic [NB-1:0] sw_set,
  input  logic [NB-1:0] sw_clr,
  input  logic [NB-1:0] ack_clr,
  output logic [NB-1:0] pend_q,
  output logic [NB-1:0] pend_d
);
  // set sources win over clear sources in the same cycle
  always_comb pend_d = (pend_q & ~sw_clr & ~ack_clr) | hw_req | sw_set;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R1
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_req != '0) |=> ((pend_q & $past(hw_req)) == $past(hw_req)));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NSRC = 8,
  parameter int IW   = 4
) (
  input  logic [NSRC:0]   pend,
  input  logic [NSRC-1:0] mask,
  input  logic            glob_en,
  output logic            any,
  output logic [IW-1:0]   sel
);
  logic [NSRC-1:0] elig;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_elig
    assign elig[gi] = pend[gi] & mask[gi] & glob_en;
  end

  always_comb begin
    any = pend[NSRC] | (|elig);
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) sel = IW'(i);
    end
    if (pend[NSRC]) sel = IW'(NSRC);
  end
endmodule

// File: rtl/irq_vtable.sv
module irq_vtable #(
  parameter int          NENT    = 9,
  parameter int          IW      = 4,
  parameter int          AW      = 32,
  parameter logic [AW-1:0] DEF_VEC = 32'h0000_0E00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [AW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [AW-1:0] rdata_b
);
  localparam logic [IW:0] LIM = (IW+1)'(NENT);

  logic [AW-1:0] mem [NENT];
  logic [NENT-1:0] written_q;

  always_ff @(posedge clk) begin
    if (we && ({1'b0, widx} < LIM)) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) written_q <= '0;
    else if (we && ({1'b0, widx} < LIM)) written_q[widx] <= 1'b1;
  end

  always_comb begin
    rdata_a = DEF_VEC;
    rdata_b = DEF_VEC;
    if ({1'b0, ridx_a} < LIM && written_q[ridx_a]) rdata_a = mem[ridx_a];
    if ({1'b0, ridx_b} < LIM && written_q[ridx_b]) rdata_b = mem[ridx_b];
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int            NSRC    = 8,
  parameter int            AW      = 32,
  parameter logic [AW-1:0] DEF_VEC = 32'h0000_0E00,
  localparam int           NENT    = NSRC + 1,
  localparam int           IW      = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_lines,
  input  logic            nmi_line,
  input  logic            cfg_wr,
  input  logic [5:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            irq_o,
  output logic [IW-1:0]   src_o,
  output logic [AW-1:0]   vec_o,
  input  logic            core_ack,
  input  logic [AW-1:0]   core_pc,
  output logic [AW-1:0]   ret_pc_o
);
  localparam int            NB     = NSRC + 1;
  localparam logic [IW-1:0] NMI_ID = IW'(NSRC);
  localparam logic [5:0]    VLIM   = 6'(NENT);

  logic [NB-1:0]   pend_q, pend_d, hw_req, sw_set, sw_clr, ack_clr;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            en_q, en_d;
  logic            any_d;
  logic [IW-1:0]   sel_d;
  logic [AW-1:0]   vec_d, vec_cfg;
  logic [5:0]      voff;
  logic            vec_hit, took;

  assign hw_req  = {nmi_line, irq_lines};
  assign sw_set  = (cfg_wr && cfg_addr == REG_PSET) ? cfg_wdata[NB-1:0] : '0;
  assign sw_clr  = (cfg_wr && cfg_addr == REG_PCLR) ? cfg_wdata[NB-1:0] : '0;
  assign took    = core_ack & irq_o;
  assign ack_clr = took ? (NB'(1) << src_o) : '0;
  assign voff    = cfg_addr - REG_VEC0;
  assign vec_hit = (cfg_addr >= REG_VEC0) && (voff < VLIM);
  assign mask_d  = (cfg_wr && cfg_addr == REG_MASK) ? cfg_wdata[NSRC-1:0] : mask_q;
  assign en_d    = (cfg_wr && cfg_addr == REG_CTRL) ? cfg_wdata[0] : en_q;

  irq_capture #(.NB(NB)) u_cap (
    .clk(clk), .rst(rst), .hw_req(hw_req), .sw_set(sw_set), .sw_clr(sw_clr),
    .ack_clr(ack_clr), .pend_q(pend_q), .pend_d(pend_d)
  );

  irq_prio #(.NSRC(NSRC), .IW(IW)) u_prio (
    .pend(pend_d), .mask(mask_d), .glob_en(en_d), .any(any_d), .sel(sel_d)
  );

  irq_vtable #(.NENT(NENT), .IW(IW), .AW(AW), .DEF_VEC(DEF_VEC)) u_vt (
    .clk(clk), .rst(rst), .we(cfg_wr && vec_hit), .widx(voff[IW-1:0]),
    .wdata(cfg_wdata[AW-1:0]), .ridx_a(sel_d), .rdata_a(vec_d),
    .ridx_b(voff[IW-1:0]), .rdata_b(vec_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      en_q      <= 1'b0;
      irq_o     <= 1'b0;
      src_o     <= '0;
      vec_o     <= '0;
      ret_pc_o  <= '0;
      cfg_rdata <= '0;
    end else begin
      mask_q <= mask_d;
      en_q   <= en_d;
      irq_o  <= any_d;
      src_o  <= sel_d;
      vec_o  <= vec_d;
      if (took) ret_pc_o <= core_pc;
      cfg_rdata <= '0;
      if (cfg_addr == REG_PSET)      cfg_rdata <= 32'(pend_q);
      else if (cfg_addr == REG_MASK) cfg_rdata <= 32'(mask_q);
      else if (cfg_addr == REG_CTRL) cfg_rdata <= {31'd0, en_q};
      else if (vec_hit)              cfg_rdata <= 32'(vec_cfg);
    end
  end

  logic [NB-1:0] elig_q;
  assign elig_q = pend_q & {1'b1, mask_q & {NSRC{en_q}}};

  // R2
  masked_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && src_o != NMI_ID) |-> (en_q && elig_q[src_o]));
  // R3
  nmi_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q[NSRC] |-> (irq_o && src_o == NMI_ID));
  // R4
  low_index_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && src_o != NMI_ID) |-> ((elig_q & ((NB'(1) << src_o) - NB'(1))) == '0));
  // R6
  ret_save_chk: assert property (@(posedge clk) disable iff (rst)
    took |=> (ret_pc_o == $past(core_pc)));
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (took && !hw_req[src_o] && !sw_set[src_o]) |=> !pend_q[$past(src_o)]);
  // R7
  reset_again_chk: assert property (@(posedge clk) disable iff (rst)
    (took && hw_req[src_o]) |=> pend_q[$past(src_o)]);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int          NSRC = 8;
  localparam int          IW   = 4;
  localparam logic [31:0] DEFV = 32'h0000_0E00;

  logic clk = 0, rst = 1;
  logic [NSRC-1:0] irq_lines = '0;
  logic nmi_line = 0, cfg_wr = 0, core_ack = 0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, core_pc = '0, cfg_rdata, vec_o, ret_pc_o;
  logic irq_o;
  logic [IW-1:0] src_o;

  int checks = 0, fails = 0;
  bit mon_en = 0, done = 0;
  logic [31:0] pc_ctr = 32'h4000_0000;
  logic [35:0] expq [$];

  always #2 clk = ~clk;

  irq_vector_ctrl #(.NSRC(NSRC), .DEF_VEC(DEFV)) u0 (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .nmi_line(nmi_line),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_o(irq_o), .src_o(src_o), .vec_o(vec_o), .core_ack(core_ack),
    .core_pc(core_pc), .ret_pc_o(ret_pc_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] l, input logic n);
    @(negedge clk); irq_lines = l; nmi_line = n;
    @(negedge clk); irq_lines = '0; nmi_line = 0;
  endtask

  task automatic expect_svc(input logic [IW-1:0] s, input logic [31:0] v);
    expq.push_back({s, v});
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && (expq.size() != 0 || core_ack); k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R4 scoreboard drained", 32'(expq.size()), 0);
  endtask

  // monitor: pops expected service and acknowledges it
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && irq_o) begin
        if (expq.size() == 0) begin
          chk(0, "R2 unexpected irq", 32'(src_o), 32'hFFFF_FFFF);
          core_ack = 1; core_pc = pc_ctr;
          @(negedge clk); core_ack = 0;
        end else begin
          logic [35:0] e;
          e = expq.pop_front();
          chk(src_o == e[35:32], "R4 source order", 32'(src_o), 32'(e[35:32]));
          chk(vec_o == e[31:0], "R5 vector", vec_o, e[31:0]);
          core_ack = 1; core_pc = pc_ctr;
          @(negedge clk); core_ack = 0;
          chk(ret_pc_o == pc_ctr, "R6 return pc", ret_pc_o, pc_ctr);
          pc_ctr += 4;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(irq_o == 0, "R5 reset irq", 32'(irq_o), 0);
    cfg_read(6'h00, rd); chk(rd == 0, "R1 reset pending", rd, 0);
    cfg_read(6'h15, rd); chk(rd == DEFV, "R9 default entry", rd, DEFV);

    for (int i = 0; i < 4; i++) cfg_write(6'(6'h10 + i), 32'h1000 + 32'(i) * 32'h40);
    cfg_write(6'h18, 32'h2000);
    cfg_read(6'h12, rd); chk(rd == 32'h1080, "R9 programmed entry", rd, 32'h1080);
    cfg_write(6'h02, 32'h05);
    cfg_write(6'h03, 32'h1);

    // R2: masked line stays pending but silent
    pulse(8'h02, 0);
    repeat (2) @(negedge clk);
    chk(irq_o == 0, "R2 masked silent", 32'(irq_o), 0);
    cfg_read(6'h00, rd); chk(rd == 32'h002, "R1 pulse held", rd, 32'h002);

    // R4: simultaneous nmi, 0, 2
    expect_svc(4'd8, 32'h2000); expect_svc(4'd0, 32'h1000); expect_svc(4'd2, 32'h1080);
    mon_en = 1;
    pulse(8'h05, 1);
    drain();
    cfg_read(6'h00, rd); chk(rd == 32'h002, "R2 masked kept", rd, 32'h002);

    // R2: unmask source 1
    expect_svc(4'd1, 32'h1040);
    cfg_write(6'h02, 32'h07);
    drain();

    // R10 and R3: global enable off
    cfg_write(6'h03, 32'h0);
    expect_svc(4'd8, 32'h2000);
    pulse(8'h01, 1);
    drain();
    cfg_read(6'h00, rd); chk(rd == 32'h001, "R10 gated pending kept", rd, 32'h001);
    expect_svc(4'd0, 32'h1000);
    cfg_write(6'h03, 32'h1);
    drain();

    // R8 software set, R9 default vector
    cfg_write(6'h02, 32'hFF);
    expect_svc(4'd5, DEFV);
    cfg_write(6'h00, 32'h20);
    drain();

    // R8 write-one-to-clear
    mon_en = 0;
    cfg_write(6'h03, 32'h0);
    cfg_write(6'h00, 32'h48);
    cfg_read(6'h00, rd); chk(rd == 32'h048, "R8 set pending", rd, 32'h048);
    cfg_write(6'h01, 32'h48);
    cfg_read(6'h00, rd); chk(rd == 32'h000, "R8 cleared", rd, 0);
    cfg_write(6'h03, 32'h1);
    @(negedge clk);
    chk(irq_o == 0, "R8 nothing left", 32'(irq_o), 0);

    // R7 acknowledge and new request in the same cycle
    pulse(8'h01, 0);
    chk(irq_o == 1 && src_o == 0, "R5 presented", 32'(src_o), 0);
    core_ack = 1; core_pc = 32'h0000_7770; irq_lines = 8'h01;
    @(negedge clk); core_ack = 0; irq_lines = '0;
    chk(irq_o == 1 && src_o == 0, "R7 re-set on ack", {31'd0, irq_o}, 1);
    chk(ret_pc_o == 32'h0000_7770, "R6 pc saved", ret_pc_o, 32'h0000_7770);
    core_ack = 1; core_pc = 32'h0000_8880;
    @(negedge clk); core_ack = 0;
    chk(irq_o == 0, "R6 cleared on ack", 32'(irq_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule